// File: doc/BRIEF.md
# Two-Way Byte Mailbox Memory

This block passes bytes between two processors that share one clock. It holds two separate word stores, each with a fixed direction. Port A fills the first store and port B drains it. Port B fills the second store and port A drains it. Either side can therefore leave a message for the other without arbitration. The two directions never compete for the same word.

Each port has active-low select, write and output-enable controls. It also has an address whose top bit names the store the access is meant for, a data input, and a data output. A separate output-valid flag takes the place of a three-state pin. An access whose top address bit does not match the port's allowed direction is dropped without any signal. Writes land on the rising clock edge. Read results are registered and appear one cycle after the request. When one port writes the word that the other port is reading in the same cycle, the reader receives the new byte at once.

Top module: `xfer_mailbox`

## Requirements
- R1: A write from port A (select low, write low, address bit 7 = 0) stores the input byte at word address[6:0] of store one. A read from port B of that word (select low, write high, output enable low, address bit 7 = 0) returns it.
- R2: A write from port B (select low, write low, address bit 7 = 1) stores the input byte at word address[6:0] of store two. A read from port A of that word (select low, write high, output enable low, address bit 7 = 1) returns it.
- R3: A write with address bit 7 set to the wrong value for its port (1 on port A, 0 on port B) leaves both stores unchanged.
- R4: A read with address bit 7 set to the wrong value for its port (0 on port A, 1 on port B) and output enable low raises the port's output-valid flag with data 8'h00.
- R5: With select high, a port neither writes nor reads, and its output-valid flag is 0 on the next cycle.
- R6: During a write (select low, write low), the port's output-valid flag is 0 whatever output enable is.
- R7: During a read with output enable high, the output-valid flag is 0. Whenever the flag is 0, the data output is 8'h00.
- R8: Read data and the output-valid flag change on the clock edge that samples the request. They hold their previous values before that edge.
- R9: When one port writes a word in the same cycle as the other port reads that word, the reader's output on the next cycle is the byte being written.
- R10: While reset (active low) is asserted, both output-valid flags are 0 and both data outputs are 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| aCsN | input | 1 | Port A select, active low |
| aWeN | input | 1 | Port A write, active low |
| aOeN | input | 1 | Port A output enable, active low |
| aAddr | input | 8 | Port A address; bit 7 selects the store |
| aDin | input | 8 | Port A write data |
| aDout | output | 8 | Port A read data |
| aDoutEn | output | 1 | Port A output-valid flag |
| bCsN | input | 1 | Port B select, active low |
| bWeN | input | 1 | Port B write, active low |
| bOeN | input | 1 | Port B output enable, active low |
| bAddr | input | 8 | Port B address; bit 7 selects the store |
| bDin | input | 8 | Port B write data |
| bDout | output | 8 | Port B read data |
| bDoutEn | output | 1 | Port B output-valid flag |

## Verification
Every result comes out of exactly one register. Stores are written on the edge that samples the request, and read data with its valid flag appears just after that same edge. The bench drives each stimulus on a falling edge and compares both ports shortly after the following rising edge. A directed test also samples a quarter period before that edge, to confirm the previous values still hold. Writes are checked by reading the word back in a later cycle. A collision is checked on the cycle that contains the write, and again on the cycle after it, when the store itself must hold the new byte.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  // Per-port strobes from the mode decode to the datapath
  typedef struct packed {
    logic wrEn;   // write allowed into this port's outgoing store
    logic rdEn;   // read allowed from this port's incoming store
    logic drive;  // read mode with output enabled
  } portStb_t;

endpackage

// File: rtl/mbx_port_ctrl.sv
module mbx_port_ctrl
  import mbx_pkg::*;
#(
  parameter logic WRITE_HIGH = 1'b0  // value of the store bit this port writes with
) (
  input  logic     csN,
  input  logic     weN,
  input  logic     oeN,
  input  logic     areaBit,
  output portStb_t stb
);

  logic selected;
  logic writeMode;
  logic readMode;

  always_comb begin
    selected  = !csN;
    writeMode = selected && !weN;
    readMode  = selected && weN;
    stb.wrEn  = writeMode && (areaBit == WRITE_HIGH);
    stb.rdEn  = readMode && (areaBit != WRITE_HIGH);
    stb.drive = readMode && !oeN;
  end

endmodule

// File: rtl/mbx_lane.sv
module mbx_lane
  import mbx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  portStb_t          wrStb,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  portStb_t          rdStb,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] store [DEPTH];
  logic              collide;
  logic [DATA_W-1:0] fetched;

  always_ff @(posedge clk) begin
    if (wrStb.wrEn) store[wrIdx] <= wrData;
  end

  always_comb begin
    collide = wrStb.wrEn && rdStb.rdEn && (wrIdx == rdIdx);
    fetched = collide ? wrData : store[rdIdx];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= rdStb.drive;
      rdData  <= (rdStb.drive && rdStb.rdEn) ? fetched : '0;
    end
  end

endmodule

// File: rtl/xfer_mailbox.sv
module xfer_mailbox
  import mbx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 7,
  localparam int ADDR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              aCsN,
  input  logic              aWeN,
  input  logic              aOeN,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic [DATA_W-1:0] aDin,
  output logic [DATA_W-1:0] aDout,
  output logic              aDoutEn,
  input  logic              bCsN,
  input  logic              bWeN,
  input  logic              bOeN,
  input  logic [ADDR_W-1:0] bAddr,
  input  logic [DATA_W-1:0] bDin,
  output logic [DATA_W-1:0] bDout,
  output logic              bDoutEn
);

  portStb_t aStb;
  portStb_t bStb;

  // Port A writes with store bit 0, port B with store bit 1
  mbx_port_ctrl #(.WRITE_HIGH(1'b0)) i_ctrlA (
    .csN(aCsN), .weN(aWeN), .oeN(aOeN), .areaBit(aAddr[ADDR_W-1]), .stb(aStb)
  );

  mbx_port_ctrl #(.WRITE_HIGH(1'b1)) i_ctrlB (
    .csN(bCsN), .weN(bWeN), .oeN(bOeN), .areaBit(bAddr[ADDR_W-1]), .stb(bStb)
  );

  // Store one: A to B
  mbx_lane #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_laneAtoB (
    .clk(clk), .rstN(rstN),
    .wrStb(aStb), .wrIdx(aAddr[IDX_W-1:0]), .wrData(aDin),
    .rdStb(bStb), .rdIdx(bAddr[IDX_W-1:0]),
    .rdData(bDout), .rdValid(bDoutEn)
  );

  // Store two: B to A
  mbx_lane #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_laneBtoA (
    .clk(clk), .rstN(rstN),
    .wrStb(bStb), .wrIdx(bAddr[IDX_W-1:0]), .wrData(bDin),
    .rdStb(aStb), .rdIdx(aAddr[IDX_W-1:0]),
    .rdData(aDout), .rdValid(aDoutEn)
  );

endmodule

// File: rtl/xfer_mailbox_chk.sv
module xfer_mailbox_chk #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              aCsN,
  input logic              aWeN,
  input logic              aOeN,
  input logic [IDX_W:0]    aAddr,
  input logic [DATA_W-1:0] aDin,
  input logic [DATA_W-1:0] aDout,
  input logic              aDoutEn,
  input logic              bCsN,
  input logic              bWeN,
  input logic              bOeN,
  input logic [IDX_W:0]    bAddr,
  input logic [DATA_W-1:0] bDin,
  input logic [DATA_W-1:0] bDout,
  input logic              bDoutEn
);

  AST_A_NOSEL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    aCsN |=> !aDoutEn);  // R5
  AST_B_NOSEL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    bCsN |=> !bDoutEn);  // R5
  AST_A_WRITE_UNDRIVEN: assert property (@(posedge clk) disable iff (!rstN)
    (!aCsN && !aWeN) |=> !aDoutEn);  // R6
  AST_B_WRITE_UNDRIVEN: assert property (@(posedge clk) disable iff (!rstN)
    (!bCsN && !bWeN) |=> !bDoutEn);  // R6
  AST_A_READ_DRIVES: assert property (@(posedge clk) disable iff (!rstN)
    (!aCsN && aWeN && !aOeN) |=> aDoutEn);  // R8
  AST_B_READ_DRIVES: assert property (@(posedge clk) disable iff (!rstN)
    (!bCsN && bWeN && !bOeN) |=> bDoutEn);  // R8
  AST_A_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !aDoutEn |-> (aDout == '0));  // R7
  AST_B_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !bDoutEn |-> (bDout == '0));  // R7
  AST_A_WRONG_AREA_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (!aCsN && aWeN && !aAddr[IDX_W]) |=> (aDout == '0));  // R4
  AST_B_WRONG_AREA_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (!bCsN && bWeN && bAddr[IDX_W]) |=> (bDout == '0));  // R4
  AST_A_COLLIDE_BYPASS: assert property (@(posedge clk) disable iff (!rstN)
    (!aCsN && aWeN && !aOeN && aAddr[IDX_W] && !bCsN && !bWeN && bAddr[IDX_W]
     && (aAddr[IDX_W-1:0] == bAddr[IDX_W-1:0])) |=> (aDout == $past(bDin)));  // R9
  AST_B_COLLIDE_BYPASS: assert property (@(posedge clk) disable iff (!rstN)
    (!bCsN && bWeN && !bOeN && !bAddr[IDX_W] && !aCsN && !aWeN && !aAddr[IDX_W]
     && (aAddr[IDX_W-1:0] == bAddr[IDX_W-1:0])) |=> (bDout == $past(aDin)));  // R9

  always @(posedge clk) begin
    if (!rstN) begin
      AST_RESET_QUIET: assert (!aDoutEn && !bDoutEn);  // R10
    end
  end

endmodule

bind xfer_mailbox xfer_mailbox_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_chk (
  .clk(clk), .rstN(rstN),
  .aCsN(aCsN), .aWeN(aWeN), .aOeN(aOeN), .aAddr(aAddr), .aDin(aDin),
  .aDout(aDout), .aDoutEn(aDoutEn),
  .bCsN(bCsN), .bWeN(bWeN), .bOeN(bOeN), .bAddr(bAddr), .bDin(bDin),
  .bDout(bDout), .bDoutEn(bDoutEn)
);

// File: tb/test_xfer_mailbox.sv
module test_xfer_mailbox;

  localparam int PERIOD = 10;
  localparam int NVEC   = 14;

  typedef struct packed {
    logic       aCs, aWe, aOe;
    logic [7:0] aAd, aDi;
    logic       bCs, bWe, bOe;
    logic [7:0] bAd, bDi;
    logic       eAEn;
    logic [7:0] eAD;
    logic       eBEn;
    logic [7:0] eBD;
    logic [7:0] tag;
  } vec_t;

  // fields: A cs,we,oe,addr,din | B cs,we,oe,addr,din | expected A en,dout | B en,dout | requirement
  localparam vec_t VECS [NVEC] = '{
    '{1'b0,1'b0,1'b0,8'h05,8'h3C, 1'b1,1'b1,1'b1,8'h00,8'h00, 1'b0,8'h00, 1'b0,8'h00, 8'd6}, // R6 A write, OE low
    '{1'b0,1'b0,1'b1,8'h7F,8'hA5, 1'b0,1'b0,1'b0,8'h80,8'h5A, 1'b0,8'h00, 1'b0,8'h00, 8'd6}, // R6 both write
    '{1'b0,1'b1,1'b0,8'h80,8'h00, 1'b0,1'b1,1'b0,8'h05,8'h00, 1'b1,8'h5A, 1'b1,8'h3C, 8'd1}, // R1 read back
    '{1'b1,1'b1,1'b1,8'h00,8'h00, 1'b0,1'b0,1'b1,8'hFF,8'hC3, 1'b0,8'h00, 1'b0,8'h00, 8'd2}, // R2 B write top word
    '{1'b0,1'b1,1'b0,8'hFF,8'h00, 1'b0,1'b1,1'b0,8'h7F,8'h00, 1'b1,8'hC3, 1'b1,8'hA5, 8'd2}, // R2 top words
    '{1'b0,1'b0,1'b0,8'h80,8'hEE, 1'b0,1'b0,1'b0,8'h05,8'h11, 1'b0,8'h00, 1'b0,8'h00, 8'd3}, // R3 wrong-area writes
    '{1'b0,1'b1,1'b0,8'h80,8'h00, 1'b0,1'b1,1'b0,8'h05,8'h00, 1'b1,8'h5A, 1'b1,8'h3C, 8'd3}, // R3 unchanged
    '{1'b0,1'b1,1'b0,8'h05,8'h00, 1'b0,1'b1,1'b0,8'h80,8'h00, 1'b1,8'h00, 1'b1,8'h00, 8'd4}, // R4 wrong-area reads
    '{1'b1,1'b0,1'b0,8'h05,8'h77, 1'b1,1'b0,1'b0,8'h80,8'h88, 1'b0,8'h00, 1'b0,8'h00, 8'd5}, // R5 deselected writes
    '{1'b0,1'b1,1'b0,8'h80,8'h00, 1'b0,1'b1,1'b0,8'h05,8'h00, 1'b1,8'h5A, 1'b1,8'h3C, 8'd5}, // R5 nothing written
    '{1'b0,1'b1,1'b1,8'h80,8'h00, 1'b0,1'b1,1'b1,8'h05,8'h00, 1'b0,8'h00, 1'b0,8'h00, 8'd7}, // R7 OE high
    '{1'b0,1'b0,1'b1,8'h05,8'h96, 1'b0,1'b1,1'b0,8'h05,8'h00, 1'b0,8'h00, 1'b1,8'h96, 8'd9}, // R9 A writes, B reads
    '{1'b0,1'b1,1'b0,8'hFF,8'h00, 1'b0,1'b0,1'b1,8'hFF,8'h69, 1'b1,8'h69, 1'b0,8'h00, 8'd9}, // R9 B writes, A reads
    '{1'b0,1'b1,1'b0,8'hFF,8'h00, 1'b0,1'b1,1'b0,8'h05,8'h00, 1'b1,8'h69, 1'b1,8'h96, 8'd9}  // R9 stores updated
  };

  logic       clk = 1'b0;
  logic       rstN;
  logic       aCsN, aWeN, aOeN, bCsN, bWeN, bOeN;
  logic [7:0] aAddr, aDin, bAddr, bDin;
  logic [7:0] aDout, bDout;
  logic       aDoutEn, bDoutEn;

  int  total = 0;
  int  bad = 0;
  bit  finished = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  xfer_mailbox i_xfer_mailbox (
    .clk(clk), .rstN(rstN),
    .aCsN(aCsN), .aWeN(aWeN), .aOeN(aOeN), .aAddr(aAddr), .aDin(aDin),
    .aDout(aDout), .aDoutEn(aDoutEn),
    .bCsN(bCsN), .bWeN(bWeN), .bOeN(bOeN), .bAddr(bAddr), .bDin(bDin),
    .bDout(bDout), .bDoutEn(bDoutEn)
  );

  task automatic idle();
    aCsN = 1'b1; aWeN = 1'b1; aOeN = 1'b1; aAddr = 8'h00; aDin = 8'h00;
    bCsN = 1'b1; bWeN = 1'b1; bOeN = 1'b1; bAddr = 8'h00; bDin = 8'h00;
  endtask

  task automatic checkPort(input string req, input string port,
                           input logic gotEn, input logic [7:0] gotD,
                           input logic expEn, input logic [7:0] expD);
    total++;
    if (gotEn !== expEn || gotD !== expD) begin
      bad++;
      $display("FAIL %s port %s: actual en=%b data=%h expected en=%b data=%h",
               req, port, gotEn, gotD, expEn, expD);
    end
  endtask

  task automatic finish();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    rstN = 1'b0;
    idle();
    repeat (3) @(posedge clk);
    #1;
    checkPort("R10", "A", aDoutEn, aDout, 1'b0, 8'h00);
    checkPort("R10", "B", bDoutEn, bDout, 1'b0, 8'h00);
    @(negedge clk) rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      aCsN = VECS[i].aCs; aWeN = VECS[i].aWe; aOeN = VECS[i].aOe;
      aAddr = VECS[i].aAd; aDin = VECS[i].aDi;
      bCsN = VECS[i].bCs; bWeN = VECS[i].bWe; bOeN = VECS[i].bOe;
      bAddr = VECS[i].bAd; bDin = VECS[i].bDi;
      @(posedge clk);
      #1;
      checkPort($sformatf("R%0d vec%0d", VECS[i].tag, i), "A",
                aDoutEn, aDout, VECS[i].eAEn, VECS[i].eAD);
      checkPort($sformatf("R%0d vec%0d", VECS[i].tag, i), "B",
                bDoutEn, bDout, VECS[i].eBEn, VECS[i].eBD);
    end

    // R8: outputs keep old values until the sampling edge
    @(negedge clk) idle();
    @(posedge clk);
    @(negedge clk);
    bCsN = 1'b0; bOeN = 1'b0; bAddr = 8'h05;
    #(PERIOD/4);
    checkPort("R8 before edge", "B", bDoutEn, bDout, 1'b0, 8'h00);
    @(posedge clk);
    #1;
    checkPort("R8 after edge", "B", bDoutEn, bDout, 1'b1, 8'h96);

    // R10: reset mid-run clears outputs, read still requested
    @(negedge clk) rstN = 1'b0;
    #1;
    checkPort("R10 mid-run", "B", bDoutEn, bDout, 1'b0, 8'h00);
    checkPort("R10 mid-run", "A", aDoutEn, aDout, 1'b0, 8'h00);
    @(negedge clk) rstN = 1'b1;
    @(posedge clk);
    #1;
    checkPort("R1 after reset", "B", bDoutEn, bDout, 1'b1, 8'h96);

    finish();
  end

  initial begin
    #(PERIOD * 5000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R8 watchdog: actual=hung expected=done");
      finish();
    end
  end

endmodule